// File: doc/BRIEF.md
# Blocked-Thread Context Switch Controller

This block decides which of several hardware thread contexts owns a single-issue pipeline. The running context keeps fetching until it reports a long-latency event, such as a first-level cache miss or an unpipelined divide. When that happens the controller marks the context blocked and stores the PC to replay. It then tells the pipeline to squash everything tagged with that context. Fetch stays off for a fixed switch window, and then the controller hands fetch to the next ready context in round-robin order.

Every context has its own PC, so a switch needs no save or restore through memory. A completion event only sets the ready flag of the context it names and never takes the pipeline away from the running context. If no context is ready when one is needed, fetch stays off until a completion arrives. The register files, caches and long-latency units are outside this block. The pipeline tags each fetched instruction with the active context ID and squashes by that tag when flush is raised.

Top module: `ctx_switch_ctl`

## Requirements
- R1: After reset all contexts are ready and context 0 runs. `fetch_valid_o` is 1, `active_ctx_o` is 0, `fetch_pc_o` is BASE_PC, and `flush_o` is 0. Context i starts at BASE_PC + i*CTX_STRIDE.
- R2: While a context runs and `trig_i` is low, `fetch_pc_o` advances by INSN_BYTES every cycle and `active_ctx_o` does not change.
- R3: When `trig_i` is sampled high while fetching, `flush_o` is 1 for exactly the next cycle, and `flush_ctx_o` holds the context that was running.
- R4: After a trigger, `fetch_valid_o` is 0 for exactly SWITCH_CYCLES cycles. This holds when a ready context exists at the end of that window.
- R5: The next context is the first ready one in round-robin order, starting at the blocked context plus one (modulo NUM_CTX). The blocked context itself is the last candidate.
- R6: A resumed context fetches first from its saved PC. For a context that was blocked, that is the `trig_pc_i` given when it blocked.
- R7: A completion (`done_valid_i` with `done_ctx_i`) sets only that context's ready flag. It never changes the running context or its fetch stream.
- R8: If no context is ready at the end of the switch window, `fetch_valid_o` stays 0. Fetch resumes one cycle after the ready flag set by a completion is first seen.
- R9: `trig_i` is ignored while `fetch_valid_o` is 0. It causes no flush and does not change any saved PC.
- R10: A completion for a context that is already ready has no effect. A completion for the running context in the same cycle as its trigger loses, and that context stays blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Long-latency event of the running context |
| trig_pc_i | input | PC_W | PC at which the blocked context must resume |
| done_valid_i | input | 1 | A long-latency event completed |
| done_ctx_i | input | CTX_W | Context whose event completed |
| fetch_valid_o | output | 1 | Fetch enabled this cycle |
| fetch_pc_o | output | PC_W | Fetch address of the active context |
| active_ctx_o | output | CTX_W | Context ID to tag fetched instructions with |
| flush_o | output | 1 | Squash in-flight instructions tagged `flush_ctx_o` |
| flush_ctx_o | output | CTX_W | Context being squashed |

## Verification
A wrong ready flag would not show until the next switch. At that point the round-robin pick would land on the wrong context, or fetch would wrongly idle or resume, within SWITCH_CYCLES+1 cycles of the trigger. A corrupted saved PC would show on the first fetch after that context resumes, which can be many switches later. For this reason the bench keeps running long random trigger and completion sequences and compares every cycle against a reference model. A wrong active context or a missing flush shows on the very next cycle.

// File: rtl/ctx_switch_ctl.sv
module ctx_switch_ctl #(
  parameter int NUM_CTX       = 4,
  parameter int PC_W          = 32,
  parameter int SWITCH_CYCLES = 3,
  parameter int INSN_BYTES    = 4,
  parameter logic [31:0] BASE_PC    = 32'h0000_1000,
  parameter logic [31:0] CTX_STRIDE = 32'h0000_0100,
  localparam int CTX_W = $clog2(NUM_CTX),
  localparam int CNT_W = $clog2(SWITCH_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [PC_W-1:0]  trig_pc_i,
  input  logic             done_valid_i,
  input  logic [CTX_W-1:0] done_ctx_i,
  output logic             fetch_valid_o,
  output logic [PC_W-1:0]  fetch_pc_o,
  output logic [CTX_W-1:0] active_ctx_o,
  output logic             flush_o,
  output logic [CTX_W-1:0] flush_ctx_o
);

  typedef enum logic [1:0] {RUN, SWAP, IDLE} mode_t;

  mode_t              mode_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CTX_W-1:0]   act_q;
  logic [NUM_CTX-1:0] rdy_q, rdy_d;
  logic [PC_W-1:0]    pc_q [NUM_CTX];
  logic               take;
  logic               pick_ok;
  logic [CTX_W-1:0]   pick;

  assign take          = (mode_q == RUN) && trig_i;
  assign fetch_valid_o = (mode_q == RUN);
  assign fetch_pc_o    = pc_q[act_q];
  assign active_ctx_o  = act_q;

  always_comb begin
    pick_ok = 1'b0;
    pick    = act_q;
    for (int k = 1; k <= NUM_CTX; k++) begin
      int j;
      j = (int'(act_q) + k) % NUM_CTX;
      if (!pick_ok && rdy_q[j]) begin
        pick_ok = 1'b1;
        pick    = CTX_W'(j);
      end
    end
  end

  always_comb begin
    rdy_d = rdy_q;
    if (done_valid_i && int'(done_ctx_i) < NUM_CTX) rdy_d[done_ctx_i] = 1'b1;
    if (take) rdy_d[act_q] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= RUN;
      cnt_q       <= '0;
      act_q       <= '0;
      rdy_q       <= '1;
      flush_o     <= 1'b0;
      flush_ctx_o <= '0;
      for (int i = 0; i < NUM_CTX; i++)
        pc_q[i] <= PC_W'(BASE_PC + CTX_STRIDE * i);
    end else begin
      rdy_q   <= rdy_d;
      flush_o <= take;
      if (take) flush_ctx_o <= act_q;
      case (mode_q)
        RUN: begin
          if (trig_i) begin
            pc_q[act_q] <= trig_pc_i;
            mode_q      <= SWAP;
            cnt_q       <= CNT_W'(SWITCH_CYCLES - 1);
          end else begin
            pc_q[act_q] <= pc_q[act_q] + PC_W'(INSN_BYTES);
          end
        end
        SWAP: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (pick_ok) begin
            mode_q <= RUN;
            act_q  <= pick;
          end else mode_q <= IDLE;
        end
        default: begin
          if (pick_ok) begin
            mode_q <= RUN;
            act_q  <= pick;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ctx_switch_chk.sv
module ctx_switch_chk #(
  parameter int NUM_CTX    = 4,
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4,
  localparam int CTX_W = $clog2(NUM_CTX)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             fetch_valid_o,
  input logic [PC_W-1:0]  fetch_pc_o,
  input logic [CTX_W-1:0] active_ctx_o,
  input logic             flush_o,
  input logic [CTX_W-1:0] flush_ctx_o
);

  p_flush_after_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_o && trig_i) |=> (flush_o && flush_ctx_o == $past(active_ctx_o)));

  p_flush_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  p_no_fetch_on_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !fetch_valid_o);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_o && !trig_i) |=> (fetch_pc_o == $past(fetch_pc_o) + PC_W'(INSN_BYTES)));

  p_no_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_o && !trig_i) |=> (fetch_valid_o && $stable(active_ctx_o)));

  p_trig_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid_o |=> !flush_o);

endmodule

bind ctx_switch_ctl ctx_switch_chk #(
  .NUM_CTX(NUM_CTX), .PC_W(PC_W), .INSN_BYTES(INSN_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .fetch_valid_o(fetch_valid_o),
  .fetch_pc_o(fetch_pc_o), .active_ctx_o(active_ctx_o), .flush_o(flush_o),
  .flush_ctx_o(flush_ctx_o)
);

// File: tb/tb_ctx_switch_ctl.sv
module tb_ctx_switch_ctl;
  localparam int N    = 4;
  localparam int SWC  = 3;
  localparam int INSN = 4;
  localparam int CW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0;
  logic [31:0] trig_pc_i = '0;
  logic done_valid_i = 1'b0;
  logic [CW-1:0] done_ctx_i = '0;
  logic fetch_valid_o, flush_o;
  logic [31:0] fetch_pc_o;
  logic [CW-1:0] active_ctx_o, flush_ctx_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ctx_switch_ctl #(.NUM_CTX(N), .PC_W(32), .SWITCH_CYCLES(SWC), .INSN_BYTES(INSN)) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .trig_pc_i(trig_pc_i),
    .done_valid_i(done_valid_i), .done_ctx_i(done_ctx_i),
    .fetch_valid_o(fetch_valid_o), .fetch_pc_o(fetch_pc_o),
    .active_ctx_o(active_ctx_o), .flush_o(flush_o), .flush_ctx_o(flush_ctx_o));

  int m_st, m_cnt, m_act, m_flc;
  bit m_fl;
  bit [N-1:0] m_rdy;
  logic [31:0] m_pc [N];

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_act = 0; m_fl = 0; m_flc = 0; m_rdy = '1;
    for (int i = 0; i < N; i++) m_pc[i] = 32'h1000 + 32'h100 * i;
  endtask

  task automatic model_edge(bit t, logic [31:0] tp, bit dv, int dc);
    int pk;
    bit found;
    bit [N-1:0] nr;
    found = 0; pk = m_act;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (m_act + k) % N;
      if (!found && m_rdy[j]) begin found = 1; pk = j; end
    end
    nr = m_rdy;
    if (dv) nr[dc] = 1'b1;
    m_fl = 0;
    case (m_st)
      0: if (t) begin
           nr[m_act] = 1'b0; m_pc[m_act] = tp; m_fl = 1; m_flc = m_act;
           m_st = 1; m_cnt = SWC - 1;
         end else m_pc[m_act] = m_pc[m_act] + INSN;
      1: if (m_cnt != 0) m_cnt--;
         else if (found) begin m_st = 0; m_act = pk; end
         else m_st = 2;
      default: if (found) begin m_st = 0; m_act = pk; end
    endcase
    m_rdy = nr;
  endtask

  task automatic compare(string tag);
    bit ok;
    ok = 1;
    checks++;
    if (fetch_valid_o !== (m_st == 0)) begin
      ok = 0;
      $display("FAIL %s (R4/R8 fetch_valid) actual %0b expected %0b", tag, fetch_valid_o, m_st == 0);
    end
    if (m_st == 0 && active_ctx_o !== CW'(m_act)) begin
      ok = 0;
      $display("FAIL %s (R5 active_ctx) actual %0d expected %0d", tag, active_ctx_o, m_act);
    end
    if (m_st == 0 && fetch_pc_o !== m_pc[m_act]) begin
      ok = 0;
      $display("FAIL %s (R6 fetch_pc) actual %h expected %h", tag, fetch_pc_o, m_pc[m_act]);
    end
    if (flush_o !== m_fl || (m_fl && flush_ctx_o !== CW'(m_flc))) begin
      ok = 0;
      $display("FAIL %s (R3 flush) actual %0b/%0d expected %0b/%0d", tag, flush_o, flush_ctx_o, m_fl, m_flc);
    end
    if (!ok) errors++;
  endtask

  task automatic step(bit t, logic [31:0] tp, bit dv, int dc, string tag);
    trig_i = t; trig_pc_i = tp; done_valid_i = dv; done_ctx_i = CW'(dc);
    @(posedge clk);
    model_edge(t, tp, dv, dc);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_steps(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 32'h0, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");
    idle_steps(3, "R2 sequential fetch");
    step(1, 32'h1008, 0, 0, "R3 trigger ctx0");
    idle_steps(SWC, "R4 switch window then R5 pick ctx1");
    step(0, 32'h0, 1, 0, "R7 completion ctx0 no preempt");
    step(0, 32'h0, 1, 2, "R10 completion for ready ctx2");
    step(1, 32'h2000, 0, 0, "R3 trigger ctx1");
    step(1, 32'hdead, 0, 0, "R9 trigger during switch ignored");
    idle_steps(SWC - 1, "R5 pick ctx2");
    step(1, 32'h3000, 1, 2, "R10 trigger beats same-cycle completion");
    idle_steps(SWC, "R5 pick ctx3");
    step(1, 32'h4000, 0, 0, "R3 trigger ctx3");
    idle_steps(SWC, "R6 ctx0 resumes at saved pc");
    step(1, 32'h1100, 0, 0, "R3 trigger ctx0");
    idle_steps(SWC + 3, "R8 no context ready");
    step(1, 32'h5000, 0, 0, "R9 trigger while idle ignored");
    step(0, 32'h0, 1, 1, "R8 completion ctx1");
    idle_steps(2, "R6 ctx1 resumes at saved pc");
    for (int i = 0; i < 3000; i++) begin
      bit t, dv;
      t  = ($urandom % 6) == 0;
      dv = ($urandom % 4) == 0;
      step(t, {$urandom} & 32'hffff_fffc, dv, int'($urandom % N), "R5 random traffic");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired (R1) actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule